// File: doc/BRIEF.md
# Acceleration Register Read Port over SPI

This block is an SPI slave that gives a host read access to six 8-bit acceleration output registers, two per axis, for three axes. The sample values come in on parallel input ports. The host lowers chip select and clocks in one command byte: a register address, a read/write flag and an odd parity bit. While that byte is clocked in, the block shifts out a status byte. The selected register then follows, most significant bit first.

If the host holds chip select low and keeps clocking, the block enters a burst. After every further eight clocks it steps the address down by one and sends the next register with no parity bit. Below the X low byte, the address wraps to the Z high byte.

The status byte carries four flags and the parity of the addressed register:
- a flag for a malformed previous frame;
- a flag set by reset;
- the self-test input;
- the saturation input.

Top module: `acc_spi_reader`

## Requirements
- R1: The command byte is sent MSB first. Bits 7:2 are the register address, bit 1 is the direction (0 means read), and bit 0 makes the count of ones in the whole byte odd.
- R2: MOSI is sampled on rising SCK and MISO changes only on falling SCK. The first MISO bit is valid after chip select falls. MISO is high impedance while chip select is high.
- R3: During the command byte, MISO carries a status byte, MSB first:
  - bit 7: frame-error flag;
  - bit 6: reset flag;
  - bit 5: self-test input;
  - bit 4: saturation input;
  - bits 3:1: zero;
  - bit 0: odd parity over the 8 bits of the register named by the command's address field (1 when that register reads 00h).
- R4: Register map: 04h is X bits 7:0, 05h is X bits 15:8, 06h is Y low, 07h is Y high, 08h is Z low and 09h is Z high. The second byte of a frame is the addressed register, MSB first.
- R5: Each further 8 clocks with chip select low return the register one address lower, with no parity bit between bytes.
- R6: In a burst, the step down from 04h goes to 09h.
- R7: Every data byte of a frame is 00h in any of these cases:
  - the command parity is even;
  - the direction bit is 1;
  - the address is outside 04h to 09h.

  A burst that starts outside the bank stays at 00h.
- R8: The frame-error flag is set at the end of a frame in either of these cases:
  - the frame has 8 or more clocks and the command parity is even;
  - the clock count is not a multiple of 8.

  It is reported in bit 7 of the next frame's status byte. It is then replaced by that frame's own outcome.
- R9: The reset flag is 1 after reset. It clears at the end of the first frame that meets all of these conditions: a valid-parity read command, at least 16 clocks, and a clock count that is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high impedance when deselected |
| x_acc | input | 16 | X-axis sample |
| y_acc | input | 16 | Y-axis sample |
| z_acc | input | 16 | Z-axis sample |
| self_test_ok | input | 1 | Self-test status flag |
| out_sat | input | 1 | Output saturation flag |

## Verification
The assertions assume three things about the SPI inputs:
- they are slow against the system clock, so one SCK level lasts several clock cycles;
- SCK is low when chip select changes;
- chip select and SCK never change in the same cycle.

The register inputs and status flags are assumed to hold still during a frame. The stimulus keeps to these limits: it holds each SCK level for eight system clocks and puts settle gaps of several clocks around every chip-select edge. It changes the sample and flag inputs only between frames.

// File: rtl/acc_spi_pkg.sv
package acc_spi_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int AXIS_W = 2 * DATA_W;
    localparam int N_AXES = 3;

    localparam logic [ADDR_W-1:0] ADDR_BASE = 6'h04;
    localparam logic [ADDR_W-1:0] ADDR_TOP  = 6'h09;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic frame_err;
        logic por;
        logic self_test;
        logic sat;
    } status_t;

    function automatic logic odd_fill(input logic [DATA_W-1:0] b);
        return ~(^b);
    endfunction

    function automatic logic in_bank(input logic [ADDR_W-1:0] a);
        return (a >= ADDR_BASE) && (a <= ADDR_TOP);
    endfunction

    function automatic logic [ADDR_W-1:0] step_down(input logic [ADDR_W-1:0] a);
        if (!in_bank(a))
            return a;
        if (a == ADDR_BASE)
            return ADDR_TOP;
        return a - 6'd1;
    endfunction

endpackage

// File: rtl/acc_spi_edges.sv
module acc_spi_edges
    import acc_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sck,
    input  logic  csn,
    input  logic  mosi,
    output edge_t sck_e,
    output edge_t cs_e,
    output logic  csn_s,
    output logic  mosi_s
);
    logic sck_s, sck_p, csn_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s  <= 1'b0;
            sck_p  <= 1'b0;
            csn_s  <= 1'b1;
            csn_p  <= 1'b1;
            mosi_s <= 1'b0;
        end else begin
            sck_s  <= sck;
            sck_p  <= sck_s;
            csn_s  <= csn;
            csn_p  <= csn_s;
            mosi_s <= mosi;
        end
    end

    assign sck_e.rise = sck_s & ~sck_p;
    assign sck_e.fall = ~sck_s & sck_p;
    assign cs_e.rise  = csn_s & ~csn_p;
    assign cs_e.fall  = ~csn_s & csn_p;

    // R2
    sck_edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sck_e.rise, sck_e.fall, cs_e.rise, cs_e.fall}));

endmodule

// File: rtl/acc_reg_mux.sv
module acc_reg_mux
    import acc_spi_pkg::*;
(
    input  logic [AXIS_W-1:0] x_in,
    input  logic [AXIS_W-1:0] y_in,
    input  logic [AXIS_W-1:0] z_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int SLOTS = 8;

    logic [AXIS_W-1:0] axis [N_AXES];
    logic [DATA_W-1:0] bank [SLOTS];
    logic [ADDR_W-1:0] off;

    assign axis[0] = x_in;
    assign axis[1] = y_in;
    assign axis[2] = z_in;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        assign bank[2*g]   = axis[g][DATA_W-1:0];
        assign bank[2*g+1] = axis[g][AXIS_W-1:DATA_W];
    end
    for (genvar s = 2 * N_AXES; s < SLOTS; s++) begin : g_pad
        assign bank[s] = '0;
    end

    assign off  = addr - ADDR_BASE;
    assign data = in_bank(addr) ? bank[off[2:0]] : '0;

endmodule

// File: rtl/acc_status_flags.sv
module acc_status_flags
    import acc_spi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_end,
    input  logic    frame_bad,
    input  logic    read_ok,
    input  logic    st_in,
    input  logic    sat_in,
    output status_t flags
);
    logic fe_q, por_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fe_q  <= 1'b0;
            por_q <= 1'b1;
        end else if (frame_end) begin
            fe_q <= frame_bad;
            if (read_ok && !frame_bad)
                por_q <= 1'b0;
        end
    end

    assign flags = '{frame_err: fe_q, por: por_q, self_test: st_in, sat: sat_in};

    // R9
    por_no_reassert_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(por_q));

    // R8
    fe_frame_end_only_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(fe_q));

endmodule

// File: rtl/acc_spi_reader.sv
module acc_spi_reader
    import acc_spi_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [AXIS_W-1:0] x_acc,
    input  logic [AXIS_W-1:0] y_acc,
    input  logic [AXIS_W-1:0] z_acc,
    input  logic              self_test_ok,
    input  logic              out_sat
);
    localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TWO_BYTE = CNT_W'(2 * DATA_W);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(DATA_W - 1);

    edge_t   sck_e, cs_e;
    logic    csn_s, mosi_s, active;
    status_t flags, stat_sh;

    logic [CNT_W-1:0]  cnt;
    logic [6:0]        cmd_sr;
    logic [DATA_W-1:0] data_sr, rd_data, stat_byte;
    logic [ADDR_W-1:0] cur_addr, rd_addr;
    logic              cmd_ok, par_ok, miso_q;
    logic              par_now, frame_bad, read_ok;

    acc_spi_edges i_edges (
        .clk(clk), .rst(rst), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
        .sck_e(sck_e), .cs_e(cs_e), .csn_s(csn_s), .mosi_s(mosi_s)
    );

    assign active  = ~csn_s;
    assign rd_addr = (cnt < ONE_BYTE) ? cmd_sr[6:1] : step_down(cur_addr);

    acc_reg_mux i_mux (
        .x_in(x_acc), .y_in(y_acc), .z_in(z_acc), .addr(rd_addr), .data(rd_data)
    );

    assign par_now   = ^{cmd_sr, mosi_s};
    assign stat_byte = {stat_sh, 3'b000, odd_fill(rd_data)};
    assign frame_bad = (cnt[2:0] != 3'd0) || ((cnt >= ONE_BYTE) && !par_ok);
    assign read_ok   = cmd_ok && (cnt >= TWO_BYTE);

    acc_status_flags i_flags (
        .clk(clk), .rst(rst), .frame_end(cs_e.rise), .frame_bad(frame_bad),
        .read_ok(read_ok), .st_in(self_test_ok), .sat_in(out_sat), .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cmd_sr   <= '0;
            data_sr  <= '0;
            cur_addr <= '0;
            cmd_ok   <= 1'b0;
            par_ok   <= 1'b0;
            stat_sh  <= '0;
            miso_q   <= 1'b0;
        end else if (cs_e.fall) begin
            cnt     <= '0;
            cmd_ok  <= 1'b0;
            par_ok  <= 1'b0;
            stat_sh <= flags;
            miso_q  <= flags.frame_err;
        end else if (active && sck_e.rise) begin
            if (cnt != '1)
                cnt <= cnt + 1'b1;
            if (cnt < CMD_LAST)
                cmd_sr <= {cmd_sr[5:0], mosi_s};
            if (cnt == CMD_LAST) begin
                par_ok   <= par_now;
                cmd_ok   <= par_now && !cmd_sr[0];
                cur_addr <= cmd_sr[6:1];
                data_sr  <= (par_now && !cmd_sr[0]) ? rd_data : '0;
            end else if (cnt[2:0] == 3'd7 && cnt > CMD_LAST) begin
                cur_addr <= rd_addr;
                data_sr  <= cmd_ok ? rd_data : '0;
            end
        end else if (active && sck_e.fall) begin
            if (cnt < ONE_BYTE) begin
                if (cnt != '0)
                    miso_q <= stat_byte[3'd7 - cnt[2:0]];
            end else begin
                miso_q <= data_sr[3'd7 - cnt[2:0]];
            end
        end
    end

    assign spi_miso = spi_csn ? 1'bz : miso_q;

    // R2
    miso_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!sck_e.fall && !cs_e.fall) |=> $stable(miso_q));

    // R7
    bad_cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !cmd_ok && (cnt >= ONE_BYTE) && sck_e.fall) |=> (miso_q == 1'b0));

    // R9
    por_clear_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.por) |-> $past(cs_e.rise));

endmodule

// File: tb/test_acc_spi_reader.sv
module test_acc_spi_reader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic [15:0] xa = 16'hA35C, ya = 16'h0F81, za = 16'h7E02;
    logic st = 1'b0, sat = 1'b0;
    wire  miso;
    pullup (miso);

    int checks = 0, errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    logic m_fe = 1'b0, m_por = 1'b1;

    always #10 clk = ~clk;

    acc_spi_reader i_acc_spi_reader (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .x_acc(xa), .y_acc(ya), .z_acc(za),
        .self_test_ok(st), .out_sat(sat)
    );

    function automatic logic [7:0] reg_val(input logic [5:0] a);
        case (a)
            6'h04: return xa[7:0];
            6'h05: return xa[15:8];
            6'h06: return ya[7:0];
            6'h07: return ya[15:8];
            6'h08: return za[7:0];
            6'h09: return za[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [5:0] next_a(input logic [5:0] a);
        if (a < 6'h04 || a > 6'h09) return a;
        return (a == 6'h04) ? 6'h09 : a - 6'd1;
    endfunction

    // R1: odd parity over the whole command byte
    function automatic logic [7:0] mkcmd(input logic [5:0] a, input logic wr, input logic bad);
        logic p;
        p = ~(^{a, wr});
        return {a, wr, bad ? ~p : p};
    endfunction

    // monitor: assembles MISO bytes and compares against the scoreboard
    int mbits = 0;
    logic [7:0] msh = '0;
    always @(negedge csn) mbits = 0;
    always @(posedge sck) begin
        if (!csn) begin
            msh = {msh[6:0], miso};
            mbits++;
            if (mbits == 8) begin
                mbits = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected byte actual %02h expected none", msh);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (msh !== e.val) begin
                        errors++;
                        $display("FAIL %s actual %02h expected %02h", e.tag, msh, e.val);
                    end
                end
            end
        end
    end

    task automatic frame(input logic [7:0] cmd, input int nbits, input string tag);
        logic good, bad;
        logic [5:0] a;
        exp_t e;
        good = (^cmd == 1'b1) && (cmd[1] == 1'b0);
        if (nbits >= 8) begin
            e.val = {m_fe, m_por, st, sat, 3'b000, ~(^reg_val(cmd[7:2]))};
            e.tag = {"R3/R8/R9 status ", tag};
            exp_q.push_back(e);
        end
        a = cmd[7:2];
        for (int k = 1; k < nbits / 8; k++) begin
            e.val = good ? reg_val(a) : 8'h00;
            e.tag = {(k == 1) ? "R1/R4/R7 data " : "R5/R6/R7 burst ", tag};
            exp_q.push_back(e);
            a = next_a(a);
        end
        csn = 1'b0;
        repeat (8) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? cmd[7-i] : 1'b0;
            repeat (4) @(posedge clk);
            sck = 1'b1;
            repeat (8) @(posedge clk);
            sck = 1'b0;
            repeat (4) @(posedge clk);
        end
        repeat (8) @(posedge clk);
        csn = 1'b1;
        repeat (10) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 %s bytes missing actual %0d expected 0", tag, exp_q.size());
            exp_q.delete();
        end
        bad = (nbits % 8 != 0) || (nbits >= 8 && ^cmd == 1'b0);
        m_fe = bad;
        if (!bad && good && nbits >= 16) m_por = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        #3;
        checks++;
        if (miso !== 1'b1) begin
            errors++;
            $display("FAIL R2 idle %s actual %b expected 1 (released)", tag, miso);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        idle_check("after reset");
        frame(mkcmd(6'h05, 1'b0, 1'b1), 16, "even parity read");
        frame(mkcmd(6'h05, 1'b0, 1'b0), 16, "x msb");
        frame(mkcmd(6'h04, 1'b0, 1'b0), 16, "x lsb");
        frame(mkcmd(6'h09, 1'b0, 1'b0), 40, "burst from 09");
        frame(mkcmd(6'h05, 1'b0, 1'b0), 48, "R6 wrap burst");
        frame(mkcmd(6'h06, 1'b0, 1'b0), 12, "short frame");
        frame(mkcmd(6'h07, 1'b0, 1'b0), 16, "after short frame");
        frame(mkcmd(6'h07, 1'b1, 1'b0), 24, "write flag");
        idle_check("after write frame");
        frame(mkcmd(6'h0A, 1'b0, 1'b0), 24, "unmapped");
        xa = 16'h5AF0; ya = 16'hC3C3; za = 16'h8001;
        st = 1'b1; sat = 1'b1;
        frame(mkcmd(6'h08, 1'b0, 1'b0), 32, "flags set");
        frame(mkcmd(6'h06, 1'b0, 1'b0), 24, "y pair");
        frame(mkcmd(6'h03, 1'b0, 1'b0), 24, "below bank");
        idle_check("end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule